// File: doc/BRIEF.md
# Three-Slot In-Order Instruction Decoder

This block sits between an instruction queue and three decode lanes of unequal strength. Each cycle the queue offers a window of up to three instructions. Each instruction carries a micro-op count and a flag that marks it as microcoded. The block hands the instructions to the lanes in program order. Lane 0 is the full decoder and accepts any instruction. Lanes 1 and 2 accept only single-micro-op instructions, and they may only be used once lane 0 is filled in the same cycle. The result is a widest pattern of one large instruction followed by two small ones.

The block reports how many window entries it took in the cycle (0 to 3), and the queue shifts its window by that amount before the next clock edge. The take count is the ready side of the handshake, and the per-entry valid bits are the valid side. A long instruction is either flagged as microcoded or needs more micro-ops than lane 0 handles in one pass. It is taken alone on lane 0 and then holds the whole decoder for a configurable number of cycles. Each lane also reports a program-order sequence number, so the lanes downstream can put their micro-ops back in order.

The control has two states. DECODE is the normal state. MCODE is the stall state while a long instruction occupies lane 0. The block moves from DECODE to MCODE when lane 0 takes a long instruction and the occupancy is longer than one cycle. It returns from MCODE to DECODE when the stall counter runs out. Reset forces DECODE from either state.

Top module: `dec3_issue`

## Requirements
- R1: A synchronous active-high reset forces the DECODE state, even in the middle of a stall. After reset, mc_busy is 0 and slot_seq[0] is 0.
- R2: When not busy and window entry 0 is valid, lane 0 takes entry 0 in that cycle, for any micro-op count from 1 to FAST_MAX.
- R3: Lanes 1 and 2 only take an instruction whose micro-op count is exactly 1 and whose microcoded flag is clear.
- R4: The assignment is strictly in program order: lane k (k = 1, 2) is filled only if lane k-1 is filled. The first entry that is invalid or not eligible ends decoding for that cycle, and no entry after it is taken.
- R5: take_cnt equals the number of filled lanes, and slot_vld is always 000, 001, 011 or 111.
- R6: Entry 0 is long when its microcoded flag is set or its micro-op count exceeds FAST_MAX. A long entry 0 is taken alone on lane 0 (slot_vld 001, take_cnt 1).
- R7: After a long instruction is taken, mc_busy is 1 for the next MC_CYC-1 cycles. During those cycles no lane is filled and take_cnt is 0. Decoding resumes in the cycle after that.
- R8: slot_seq[k] equals (the number of instructions taken since reset + k) modulo 2^SEQ_W, for every lane k.
- R9: With no valid entry in the window, and not busy, nothing is taken and no lane is filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | 3 | Valid bit per window entry, entry 0 oldest |
| win_uops | input | 3 x UW | Micro-op count per window entry |
| win_mcode | input | 3 | Microcoded flag per window entry |
| slot_vld | output | 3 | Lane k holds window entry k this cycle |
| slot_seq | output | 3 x SEQ_W | Program-order sequence number for each lane |
| take_cnt | output | 2 | Window entries consumed this cycle |
| mc_busy | output | 1 | Decoder held by a long instruction (MCODE state) |

## Verification
The bench builds the block with SEQ_W = 4, so the sequence numbers wrap after sixteen instructions, and a few dozen windows are enough to test wrap-around. MC_CYC stays at 4, which gives a three-cycle stall. That is long enough to place full windows inside the stall and to apply a reset in its middle. UW = 3 with FAST_MAX = 4 allows a five-micro-op instruction with the microcoded flag clear, which tests the count-based path to MCODE separately from the flag.

// File: rtl/dec3_pkg.sv
package dec3_pkg;
    localparam int NSLOT = 3;

    typedef enum logic [0:0] {
        ST_DECODE = 1'b0,
        ST_MCODE  = 1'b1
    } dec_state_e;

    typedef struct packed {
        logic valid;
        logic simple;
        logic longop;
    } ent_class_t;
endpackage

// File: rtl/dec3_classify.sv
module dec3_classify
    import dec3_pkg::*;
#(
    parameter int UW       = 3,
    parameter int FAST_MAX = 4
) (
    input  logic          vld,
    input  logic [UW-1:0] uops,
    input  logic          mcode,
    output ent_class_t    cls
);
    localparam logic [UW-1:0] ONE_UOP = UW'(1);
    localparam logic [UW:0]   FAST_LIM = (UW+1)'(FAST_MAX);

    always_comb begin
        cls.valid  = vld;
        cls.simple = vld && (uops == ONE_UOP) && !mcode;
        cls.longop = vld && (mcode || ({1'b0, uops} > FAST_LIM));
    end
endmodule

// File: rtl/dec3_mc_fsm.sv
module dec3_mc_fsm
    import dec3_pkg::*;
#(
    parameter int MC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = (MC_CYC > 2) ? $clog2(MC_CYC) : 1;

    generate
        if (MC_CYC > 1) begin : g_stall
            localparam logic [CW-1:0] LOAD_VAL = CW'(MC_CYC - 2);
            dec_state_e    state_q, state_d;
            logic [CW-1:0] cnt_q, cnt_d;

            always_ff @(posedge clk) begin
                if (rst) begin
                    state_q <= ST_DECODE;
                    cnt_q   <= '0;
                end else begin
                    state_q <= state_d;
                    cnt_q   <= cnt_d;
                end
            end

            always_comb begin
                state_d = state_q;
                cnt_d   = cnt_q;
                unique case (state_q)
                    ST_DECODE: begin
                        if (start) begin
                            state_d = ST_MCODE;
                            cnt_d   = LOAD_VAL;
                        end
                    end
                    ST_MCODE: begin
                        if (cnt_q == '0) state_d = ST_DECODE;
                        else             cnt_d   = cnt_q - 1'b1;
                    end
                    default: state_d = ST_DECODE;
                endcase
            end

            always_comb begin
                unique case (state_q)
                    ST_DECODE: busy = 1'b0;
                    ST_MCODE:  busy = 1'b1;
                    default:   busy = 1'b0;
                endcase
            end
        end else begin : g_nostall
            logic unused_in;
            assign unused_in = clk ^ rst ^ start;
            assign busy      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dec3_slot_pick.sv
module dec3_slot_pick
    import dec3_pkg::*;
(
    input  ent_class_t             cls [NSLOT],
    input  logic                   busy,
    output logic [NSLOT-1:0]       slot_vld,
    output logic [1:0]             take_cnt,
    output logic                   start_mc
);
    logic go0, go1, go2;

    always_comb begin
        go0 = !busy && cls[0].valid;
        go1 = go0 && !cls[0].longop && cls[1].simple;
        go2 = go1 && cls[2].simple;
        slot_vld = {go2, go1, go0};
        start_mc = go0 && cls[0].longop;
        if (go2)      take_cnt = 2'd3;
        else if (go1) take_cnt = 2'd2;
        else if (go0) take_cnt = 2'd1;
        else          take_cnt = 2'd0;
    end
endmodule

// File: rtl/dec3_issue.sv
module dec3_issue
    import dec3_pkg::*;
#(
    parameter int UW       = 3,
    parameter int FAST_MAX = 4,
    parameter int MC_CYC   = 4,
    parameter int SEQ_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSLOT-1:0]            win_vld,
    input  logic [NSLOT-1:0][UW-1:0]    win_uops,
    input  logic [NSLOT-1:0]            win_mcode,
    output logic [NSLOT-1:0]            slot_vld,
    output logic [NSLOT-1:0][SEQ_W-1:0] slot_seq,
    output logic [1:0]                  take_cnt,
    output logic                        mc_busy
);
    ent_class_t       cls [NSLOT];
    logic             start_mc;
    logic [SEQ_W-1:0] seq_base_q;

    for (genvar k = 0; k < NSLOT; k++) begin : g_ent
        dec3_classify #(.UW(UW), .FAST_MAX(FAST_MAX)) u_cls (
            .vld   (win_vld[k]),
            .uops  (win_uops[k]),
            .mcode (win_mcode[k]),
            .cls   (cls[k])
        );
        assign slot_seq[k] = seq_base_q + SEQ_W'(k);
    end

    dec3_slot_pick u_pick (
        .cls      (cls),
        .busy     (mc_busy),
        .slot_vld (slot_vld),
        .take_cnt (take_cnt),
        .start_mc (start_mc)
    );

    dec3_mc_fsm #(.MC_CYC(MC_CYC)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start_mc),
        .busy  (mc_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) seq_base_q <= '0;
        else     seq_base_q <= seq_base_q + SEQ_W'(take_cnt);
    end
endmodule

// File: rtl/dec3_issue_chk.sv
module dec3_issue_chk #(
    parameter int UW       = 3,
    parameter int FAST_MAX = 4,
    parameter int MC_CYC   = 4,
    parameter int SEQ_W    = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2:0]            win_vld,
    input logic [2:0][UW-1:0]    win_uops,
    input logic [2:0]            win_mcode,
    input logic [2:0]            slot_vld,
    input logic [2:0][SEQ_W-1:0] slot_seq,
    input logic [1:0]            take_cnt,
    input logic                  mc_busy
);
    logic long0;
    assign long0 = win_mcode[0] || ({1'b0, win_uops[0]} > (UW+1)'(FAST_MAX));

    AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (rst)
        (slot_vld == 3'b000 || slot_vld == 3'b001 || slot_vld == 3'b011 || slot_vld == 3'b111)); // R4

    AST_TAKE_COUNT: assert property (@(posedge clk) disable iff (rst)
        take_cnt == 2'($countones(slot_vld))); // R5

    AST_SMALL_LANES: assert property (@(posedge clk) disable iff (rst)
        slot_vld[1] |-> (win_uops[1] == UW'(1) && !win_mcode[1])); // R3

    AST_LONG_ALONE: assert property (@(posedge clk) disable iff (rst)
        (slot_vld[0] && long0) |-> (slot_vld == 3'b001)); // R6

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        mc_busy |-> (slot_vld == 3'b000 && take_cnt == 2'd0)); // R7

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> slot_seq[0] == $past(slot_seq[0]) + SEQ_W'($past(take_cnt))); // R8

    generate
        if (MC_CYC > 1) begin : g_enter
            AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (rst)
                (slot_vld[0] && long0) |=> mc_busy); // R7
        end
    endgenerate
endmodule

bind dec3_issue dec3_issue_chk #(
    .UW(UW), .FAST_MAX(FAST_MAX), .MC_CYC(MC_CYC), .SEQ_W(SEQ_W)
) u_chk (
    .clk(clk), .rst(rst), .win_vld(win_vld), .win_uops(win_uops),
    .win_mcode(win_mcode), .slot_vld(slot_vld), .slot_seq(slot_seq),
    .take_cnt(take_cnt), .mc_busy(mc_busy)
);

// File: tb/dec3_issue_test.sv
module dec3_issue_test;
    localparam int UW = 3;
    localparam int FAST_MAX = 4;
    localparam int MC_CYC = 4;
    localparam int SEQ_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]            win_vld = '0;
    logic [2:0][UW-1:0]    win_uops = '0;
    logic [2:0]            win_mcode = '0;
    logic [2:0]            slot_vld;
    logic [2:0][SEQ_W-1:0] slot_seq;
    logic [1:0]            take_cnt;
    logic                  mc_busy;

    int checks = 0;
    int fails = 0;

    logic [2:0]       q_vld [$];
    logic [1:0]       q_take [$];
    logic             q_busy [$];
    logic [SEQ_W-1:0] q_seq [$];
    string            q_tag [$];

    int               m_busy_left = 0;
    logic [SEQ_W-1:0] m_seq = '0;

    always #4 clk = ~clk;

    dec3_issue #(.UW(UW), .FAST_MAX(FAST_MAX), .MC_CYC(MC_CYC), .SEQ_W(SEQ_W)) uut (
        .clk(clk), .rst(rst), .win_vld(win_vld), .win_uops(win_uops),
        .win_mcode(win_mcode), .slot_vld(slot_vld), .slot_seq(slot_seq),
        .take_cnt(take_cnt), .mc_busy(mc_busy)
    );

    task automatic drive(input logic [2:0] v, input int u0, input int u1, input int u2,
                         input logic [2:0] mc, input string tag);
        logic [2:0] ev;
        logic [1:0] et;
        logic       eb;
        logic       lg;
        @(negedge clk);
        win_vld   = v;
        win_uops  = {UW'(u2), UW'(u1), UW'(u0)};
        win_mcode = mc;
        ev = 3'b000; et = 2'd0; eb = 1'b0;
        if (m_busy_left > 0) begin
            eb = 1'b1;
            m_busy_left = m_busy_left - 1;
        end else if (v[0]) begin
            lg = mc[0] || (u0 > FAST_MAX);
            ev = 3'b001; et = 2'd1;
            if (!lg && v[1] && u1 == 1 && !mc[1]) begin
                ev = 3'b011; et = 2'd2;
                if (v[2] && u2 == 1 && !mc[2]) begin
                    ev = 3'b111; et = 2'd3;
                end
            end
            if (lg) m_busy_left = MC_CYC - 1;
        end
        q_vld.push_back(ev);
        q_take.push_back(et);
        q_busy.push_back(eb);
        q_seq.push_back(m_seq);
        q_tag.push_back(tag);
        m_seq = m_seq + SEQ_W'(et);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        win_vld = '0;
        @(negedge clk);
        rst = 1'b0;
        m_busy_left = 0;
        m_seq = '0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (q_vld.size() > 0) begin
                logic [2:0]       ev;
                logic [1:0]       et;
                logic             eb;
                logic [SEQ_W-1:0] es;
                string            tg;
                ev = q_vld.pop_front();
                et = q_take.pop_front();
                eb = q_busy.pop_front();
                es = q_seq.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if (slot_vld !== ev || take_cnt !== et || mc_busy !== eb ||
                    slot_seq[0] !== es || slot_seq[2] !== es + SEQ_W'(2)) begin
                    fails++;
                    $display("FAIL %s: vld=%b take=%0d busy=%b seq0=%0d seq2=%0d expected vld=%b take=%0d busy=%b seq0=%0d seq2=%0d",
                             tg, slot_vld, take_cnt, mc_busy, slot_seq[0], slot_seq[2],
                             ev, et, eb, es, es + SEQ_W'(2));
                end
            end
        end
    end

    initial begin : driver
        logic finished;
        finished = 1'b0;
        fork
            begin
                do_reset();
                drive(3'b000, 1, 1, 1, 3'b000, "R1 reset state, R9 empty window");
                drive(3'b111, 1, 1, 1, 3'b000, "R2 R5 three simple");
                drive(3'b111, 4, 1, 1, 3'b000, "R2 four-uop on lane 0");
                drive(3'b111, 1, 2, 1, 3'b000, "R3 R4 two-uop in entry 1 stops");
                drive(3'b111, 1, 1, 3, 3'b000, "R3 three-uop in entry 2");
                drive(3'b101, 1, 1, 1, 3'b000, "R4 hole in window");
                drive(3'b110, 1, 1, 1, 3'b000, "R4 R9 entry 0 invalid");
                drive(3'b111, 2, 1, 1, 3'b010, "R3 microcoded in entry 1");
                drive(3'b111, 3, 1, 1, 3'b001, "R6 microcoded entry 0");
                for (int i = 0; i < MC_CYC - 1; i++)
                    drive(3'b111, 1, 1, 1, 3'b000, "R7 stall window");
                drive(3'b111, 1, 1, 1, 3'b000, "R7 resume after stall");
                drive(3'b111, 5, 1, 1, 3'b000, "R6 five-uop treated as long");
                for (int i = 0; i < MC_CYC - 1; i++)
                    drive(3'b011, 1, 1, 1, 3'b000, "R7 count-based stall");
                drive(3'b011, 1, 1, 1, 3'b000, "R7 resume two");
                for (int i = 0; i < 7; i++)
                    drive(3'b111, 1, 1, 1, 3'b000, "R8 sequence wrap");
                drive(3'b001, 6, 1, 1, 3'b001, "R6 long before reset");
                drive(3'b111, 1, 1, 1, 3'b000, "R7 first stall cycle");
                do_reset();
                drive(3'b111, 1, 1, 1, 3'b000, "R1 reset clears stall");
                drive(3'b000, 1, 1, 1, 3'b000, "R9 idle window");
                drive(3'b011, 1, 1, 1, 3'b000, "R5 two simple");
                @(negedge clk);
                @(negedge clk);
                finished = 1'b1;
            end
            begin
                #(8 * 200000);
            end
        join_any
        disable fork;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule